// File: doc/BRIEF.md
# Multi-level lookahead binary adder

This block adds two binary words in a single combinational pass. Every bit position derives a generate signal (both operand bits set) and a propagate signal (either operand bit set). Positions are gathered into groups of a parameterised size. Each group condenses its members into one group generate and one group propagate. The same grouping step repeats on the group signals, level after level, until a single lookahead unit spans the whole word. Carries then flow back down through the levels, and each bit forms its sum as the exclusive OR of its two operand bits and the carry it receives.

A control input selects subtraction. In that mode the second operand is bit-inverted and the carry into bit 0 is forced high, so the block returns the two's complement difference. The word width and the group size are parameters. Words that are not an exact power of the group size are handled by an uneven split: the last group at a level is narrower than the others. The carry out of the top bit and a signed-overflow flag are both outputs.

Top module: `cla_adder`

## Requirements
- R1: With `sub_en` = 0, {`carry_out`, `sum_o`} equals `op_a` + `op_b` + `carry_in`, taken as an unsigned (WIDTH+1)-bit value.
- R2: With `sub_en` = 1, `sum_o` equals (`op_a` − `op_b`) mod 2^WIDTH. `carry_out` is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers.
- R3: In add mode, `overflow` is 1 exactly when both operands have the same most significant bit and `sum_o` has a different one.
- R4: In subtract mode, `overflow` is 1 exactly when the operands' most significant bits differ and the most significant bit of `sum_o` differs from that of `op_a`.
- R5: With `sub_en` = 1, `carry_in` has no effect on `sum_o`, `carry_out` or `overflow`.
- R6: A carry entering bit 0 reaches every higher position. With all-ones plus zero and `carry_in` = 1, `sum_o` is 0 and `carry_out` is 1.
- R7: A carry generated inside one group reaches the first bit of the next group and of the next higher-level group, for example 0x0000FFFF + 1 = 0x00010000.
- R8: The same results hold for a group size of 2 and for a width that is not a power of the group size (WIDTH = 12, GROUP = 2).
- R9: The block holds no state. Its outputs follow a change of inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored in subtract mode |
| sum_o | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed overflow: carry into the top bit differs from carry out of it |

## Verification
The adder is driven with carry chains of full length (all ones plus a carry-in), which separate a working lookahead path from one that loses carries across levels. It is also driven with carries that start inside one group and must cross a group or super-group boundary, which expose a wrong group-generate term or a wrong level split. The signed corners at the most negative and most positive values tell a correct overflow flag apart from one that uses the wrong carry pair, and paired subtractions with `carry_in` at 0 and 1 show whether the carry-in is really overridden. A pseudo-random sweep against an arithmetic model, and a second instance with group size 2 at an uneven width, cover the general case and the irregular tree shape.

// File: rtl/cla_pkg.sv
// Package: cla_pkg
// Holds the elaboration-time helpers that size the lookahead tree.
// Assumes group size >= 2 and width >= 1.
package cla_pkg;

    // Number of grouping levels needed before one unit spans the width.
    function automatic int tree_levels(input int width, input int grp);
        int span;
        int lv;
        span = 1;
        lv   = 0;
        while (span < width) begin
            span = span * grp;
            lv   = lv + 1;
        end
        return lv;
    endfunction

    // Integer power, used for the span covered by one child subtree.
    function automatic int int_pow(input int base, input int ex);
        int r;
        r = 1;
        for (int i = 0; i < ex; i++) r = r * base;
        return r;
    endfunction

endpackage

// File: rtl/cla_bit_cell.sv
// Module: cla_bit_cell
// One bit position: forms generate and propagate from the operand bits
// and the sum bit from the carry delivered by the lookahead tree.
// Assumes the second operand has already been inverted for subtraction.
module cla_bit_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic g_o,
    output logic p_o,
    output logic s_o
);

    // Generate, propagate and sum for this position.
    always_comb begin
        g_o = x_i & y_i;
        p_o = x_i | y_i;
        s_o = x_i ^ y_i ^ c_i;
    end

endmodule

// File: rtl/cla_lookahead_node.sv
// Module: cla_lookahead_node
// One lookahead unit over N inputs (N <= group size). Each carry is a flat
// sum of products of the generate/propagate inputs and the unit's carry-in.
// The unit also condenses its inputs into a group generate and propagate.
// Assumes N >= 1.
module cla_lookahead_node #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-1:0] cin_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    logic c_term;
    logic c_acc;
    logic g_term;
    logic g_acc;

    // Flat lookahead expansion of the carry into each input position.
    always_comb begin
        c_term = 1'b0;
        c_acc  = 1'b0;
        for (int j = 0; j < N; j++) begin
            c_term = cin_i;
            for (int i = 0; i < j; i++) c_term = c_term & prop_i[i];
            c_acc = c_term;
            for (int i = 0; i < j; i++) begin
                c_term = gen_i[i];
                for (int q = i + 1; q < j; q++) c_term = c_term & prop_i[q];
                c_acc = c_acc | c_term;
            end
            cin_o[j] = c_acc;
        end
    end

    // Group generate: some input generates and all above it propagate.
    always_comb begin
        g_term = 1'b0;
        g_acc  = 1'b0;
        for (int i = 0; i < N; i++) begin
            g_term = gen_i[i];
            for (int q = i + 1; q < N; q++) g_term = g_term & prop_i[q];
            g_acc = g_acc | g_term;
        end
        grp_gen_o  = g_acc;
        grp_prop_o = &prop_i;
    end

    // R6: each flat carry agrees with a one-step ripple from its neighbour,
    // and the group outputs agree with a ripple past the top input.
    always_comb begin
        if (!$isunknown({gen_i, prop_i, cin_i})) begin
            for (int j = 1; j < N; j++) begin
                a_r6_carry_step: assert (cin_o[j] ==
                    (gen_i[j-1] | (prop_i[j-1] & cin_o[j-1])));
            end
            a_r7_group_out: assert ((grp_gen_o | (grp_prop_o & cin_i)) ==
                (gen_i[N-1] | (prop_i[N-1] & cin_o[N-1])));
        end
    end

endmodule

// File: rtl/cla_carry_tree.sv
// Module: cla_carry_tree
// Recursive lookahead tree over W bit-level generate/propagate pairs.
// At or below the group size, one lookahead unit covers the inputs.
// Above it, the inputs are split into children spanning K^(levels-1)
// bits each (the last child may be narrower), and one unit combines
// the children's group signals and hands each child its carry-in.
// Assumes K >= 2.
module cla_carry_tree #(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W-1:0] carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);

    localparam int LEVELS = cla_pkg::tree_levels(W, K);
    localparam int SPAN   = (W <= K) ? 1 : cla_pkg::int_pow(K, LEVELS - 1);
    localparam int NCH    = (W <= K) ? W : (W + SPAN - 1) / SPAN;

    generate
        if (W <= K) begin : g_leaf
            cla_lookahead_node #(.N(W)) u_node (
                .gen_i      (gen_i),
                .prop_i     (prop_i),
                .cin_i      (cin_i),
                .cin_o      (carry_o),
                .grp_gen_o  (grp_gen_o),
                .grp_prop_o (grp_prop_o)
            );
        end else begin : g_split
            logic [NCH-1:0] ch_gen;
            logic [NCH-1:0] ch_prop;
            logic [NCH-1:0] ch_cin;

            cla_lookahead_node #(.N(NCH)) u_node (
                .gen_i      (ch_gen),
                .prop_i     (ch_prop),
                .cin_i      (cin_i),
                .cin_o      (ch_cin),
                .grp_gen_o  (grp_gen_o),
                .grp_prop_o (grp_prop_o)
            );

            for (genvar ci = 0; ci < NCH; ci++) begin : g_child
                localparam int LO = ci * SPAN;
                localparam int CW = ((W - LO) < SPAN) ? (W - LO) : SPAN;
                cla_carry_tree #(.W(CW), .K(K)) u_sub (
                    .gen_i      (gen_i[LO +: CW]),
                    .prop_i     (prop_i[LO +: CW]),
                    .cin_i      (ch_cin[ci]),
                    .carry_o    (carry_o[LO +: CW]),
                    .grp_gen_o  (ch_gen[ci]),
                    .grp_prop_o (ch_prop[ci])
                );
            end
        end
    endgenerate

endmodule

// File: rtl/cla_adder.sv
// Module: cla_adder
// Top: two-operand adder/subtractor built on the recursive lookahead tree.
// Subtraction inverts the second operand and forces the carry into bit 0.
// Purely combinational; assumes WIDTH >= 2 and GROUP >= 2.
module cla_adder #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_zero;
    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;
    logic [WIDTH-1:0] bit_carry;
    logic             word_gen;
    logic             word_prop;

    // Operand conditioning for add or subtract.
    always_comb begin
        b_eff  = op_b ^ {WIDTH{sub_en}};
        c_zero = sub_en | carry_in;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            cla_bit_cell u_cell (
                .x_i (op_a[b]),
                .y_i (b_eff[b]),
                .c_i (bit_carry[b]),
                .g_o (bit_gen[b]),
                .p_o (bit_prop[b]),
                .s_o (sum_o[b])
            );
        end
    endgenerate

    cla_carry_tree #(.W(WIDTH), .K(GROUP)) u_tree (
        .gen_i      (bit_gen),
        .prop_i     (bit_prop),
        .cin_i      (c_zero),
        .carry_o    (bit_carry),
        .grp_gen_o  (word_gen),
        .grp_prop_o (word_prop)
    );

    // Carry out of the word and the signed-overflow flag.
    always_comb begin
        carry_out = word_gen | (word_prop & c_zero);
        overflow  = carry_out ^ bit_carry[MSB];
    end

    // Arithmetic cross-checks against the operand values.
    always_comb begin
        if (!$isunknown({op_a, op_b, sub_en, carry_in})) begin
            if (!sub_en) begin
                a_r1_add_result: assert ({carry_out, sum_o} ==
                    ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
                a_r3_add_overflow: assert (overflow ==
                    ((op_a[MSB] == op_b[MSB]) && (sum_o[MSB] != op_a[MSB])));
            end else begin
                a_r2_sub_result: assert (sum_o == (op_a - op_b));
                a_r2_sub_borrow: assert (carry_out == (op_a >= op_b));
                a_r4_sub_overflow: assert (overflow ==
                    ((op_a[MSB] != op_b[MSB]) && (sum_o[MSB] != op_a[MSB])));
            end
        end
    end

endmodule

// File: tb/cla_adder_tb.sv
// Bench: vector table walked by one loop, then directed and swept checks
// on the 32-bit group-4 instance and a 12-bit group-2 instance.
module cla_adder_tb;

    localparam int W  = 32;
    localparam int W2 = 12;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;

    logic [W-1:0]  a, b, s;
    logic          sub, cin, co, ov;
    logic [W2-1:0] a2, b2, s2;
    logic          sub2, cin2, co2, ov2;

    cla_adder #(.WIDTH(W), .GROUP(4)) u_dut (
        .op_a(a), .op_b(b), .sub_en(sub), .carry_in(cin),
        .sum_o(s), .carry_out(co), .overflow(ov)
    );

    cla_adder #(.WIDTH(W2), .GROUP(2)) u_dut_k2 (
        .op_a(a2), .op_b(b2), .sub_en(sub2), .carry_in(cin2),
        .sum_o(s2), .carry_out(co2), .overflow(ov2)
    );

    // Table: operands, {sub,cin}, expected sum, expected {cout,ovf}.
    localparam logic [31:0] T_A [NV] = '{
        32'h0000_0000, 32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_FFFF,
        32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0005,
        32'h0000_0003, 32'h8000_0000, 32'h0000_0005, 32'h1234_5678,
        32'h0000_0000, 32'h7FFF_FFFF };
    localparam logic [31:0] T_B [NV] = '{
        32'h0000_0000, 32'h0000_0003, 32'h0000_0000, 32'h0000_0001,
        32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0003,
        32'h0000_0005, 32'h0000_0001, 32'h0000_0003, 32'h9ABC_DEF0,
        32'h0000_0000, 32'hFFFF_FFFF };
    localparam logic [1:0] T_CTL [NV] = '{
        2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b01,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b00, 2'b10, 2'b10 };
    localparam logic [31:0] T_S [NV] = '{
        32'h0000_0000, 32'h0000_0008, 32'h0000_0000, 32'h0001_0000,
        32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0002,
        32'hFFFF_FFFE, 32'h7FFF_FFFF, 32'h0000_0002, 32'hACF1_3568,
        32'h0000_0000, 32'h8000_0000 };
    localparam logic [1:0] T_F [NV] = '{
        2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 2'b11, 2'b10,
        2'b10, 2'b00, 2'b11, 2'b10, 2'b00, 2'b10, 2'b01 };

    // Record one comparison.
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive the 32-bit instance away from the clock edge and settle.
    task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic xs, input logic xc);
        @(negedge clk);
        a = xa; b = xb; sub = xs; cin = xc;
        #1;
    endtask

    // Drive the 12-bit instance.
    task automatic drive2(input logic [W2-1:0] xa, input logic [W2-1:0] xb,
                          input logic xs, input logic xc);
        @(negedge clk);
        a2 = xa; b2 = xb; sub2 = xs; cin2 = xc;
        #1;
    endtask

    // Model-based check for either mode of the 32-bit instance.
    task automatic model_chk32(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xs, input logic xc);
        logic [W:0] r;
        logic       eo;
        drive(xa, xb, xs, xc);
        if (!xs) begin
            r  = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
            eo = (xa[W-1] == xb[W-1]) && (r[W-1] != xa[W-1]);
            chk("R1 sweep add", {31'b0, co, s}, {31'b0, r});
            chk("R3 sweep ovf", {63'b0, ov}, {63'b0, eo});
        end else begin
            r  = {1'b0, xa} - {1'b0, xb};
            eo = (xa[W-1] != xb[W-1]) && (r[W-1] != xa[W-1]);
            chk("R2 sweep sub", {32'b0, s}, {32'b0, r[W-1:0]});
            chk("R2 sweep borrow", {63'b0, co}, {63'b0, (xa >= xb)});
            chk("R4 sweep ovf", {63'b0, ov}, {63'b0, eo});
        end
    endtask

    // Model-based check for the 12-bit group-2 instance (R8).
    task automatic model_chk12(input logic [W2-1:0] xa, input logic [W2-1:0] xb, input logic xs, input logic xc);
        logic [W2:0] r;
        logic        eo;
        drive2(xa, xb, xs, xc);
        if (!xs) begin
            r  = {1'b0, xa} + {1'b0, xb} + {{W2{1'b0}}, xc};
            eo = (xa[W2-1] == xb[W2-1]) && (r[W2-1] != xa[W2-1]);
        end else begin
            r  = {1'b0, xa} + {1'b0, ~xb} + 1'b1;
            eo = (xa[W2-1] != xb[W2-1]) && (r[W2-1] != xa[W2-1]);
        end
        chk("R8 k2 result", {50'b0, co2, s2}, {50'b0, r});
        chk("R8 k2 ovf", {63'b0, ov2}, {63'b0, eo});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] s_c0;
        logic [1:0]   f_c0;
        a = '0; b = '0; sub = 1'b0; cin = 1'b0;
        a2 = '0; b2 = '0; sub2 = 1'b0; cin2 = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        // Quiet state while held in reset, zero inputs (R1).
        chk("R1 reset sum", {32'b0, s}, 64'd0);
        chk("R1 reset flags", {62'b0, co, ov}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1/R3 add rows, R2/R4 sub rows, R5 row 10,
        // R6 rows 2 and 6, R7 row 3.
        for (int i = 0; i < NV; i++) begin
            drive(T_A[i], T_B[i], T_CTL[i][1], T_CTL[i][0]);
            chk(T_CTL[i][1] ? "R2 table sum" : "R1 table sum", {32'b0, s}, {32'b0, T_S[i]});
            chk(T_CTL[i][1] ? "R4 table flags" : "R3 table flags", {62'b0, co, ov}, {62'b0, T_F[i]});
        end

        // R6: full-length carry from carry_in.
        drive(32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1);
        chk("R6 full chain", {31'b0, co, s}, {31'b0, 1'b1, 32'h0});

        // R7: carry generated in low groups crossing super-group boundaries.
        drive(32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0);
        chk("R7 group edge", {32'b0, s}, 64'h10);
        drive(32'h7FFF_FFF0, 32'h0000_0010, 1'b0, 1'b0);
        chk("R7 top group", {30'b0, co, ov, s}, {30'b0, 1'b0, 1'b1, 32'h8000_0000});

        // R5: carry_in has no effect in subtract mode.
        for (int i = 0; i < 4; i++) begin
            x = 32'h8765_4321 + 32'(i) * 32'h1111_1111;
            y = 32'h0F0F_F0F0 ^ 32'(i * 7);
            drive(x, y, 1'b1, 1'b0);
            s_c0 = s;
            f_c0 = {co, ov};
            drive(x, y, 1'b1, 1'b1);
            chk("R5 cin ignored", {30'b0, co, ov, s}, {30'b0, f_c0, s_c0});
        end

        // R9: outputs follow inputs without an intervening clock edge.
        @(negedge clk);
        a = 32'h0000_0100; b = 32'h0000_0023; sub = 1'b0; cin = 1'b0;
        #1;
        chk("R9 no clock", {32'b0, s}, 64'h123);
        a = 32'h0000_0100; b = 32'h0000_0001; sub = 1'b1;
        #1;
        chk("R9 no clock", {32'b0, s}, 64'hFF);

        // Pseudo-random sweep of both modes (R1, R2, R3, R4).
        x = 32'h1357_9BDF;
        y = 32'h2468_ACE0;
        for (int i = 0; i < 300; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y ^ (x << 3);
            model_chk32(x, y, i[0], i[1]);
        end

        // R8: group size 2 at width 12, corners then a sweep.
        drive2(12'hFFF, 12'h000, 1'b0, 1'b1);
        chk("R8 k2 chain", {51'b0, co2, s2}, {51'b0, 1'b1, 12'h000});
        drive2(12'h7FF, 12'h001, 1'b0, 1'b0);
        chk("R8 k2 ovf", {50'b0, co2, ov2, s2}, {50'b0, 1'b0, 1'b1, 12'h800});
        drive2(12'h005, 12'h007, 1'b1, 1'b0);
        chk("R8 k2 sub", {51'b0, co2, s2}, {51'b0, 1'b0, 12'hFFE});
        for (int i = 0; i < 400; i++) begin
            model_chk12(12'((i * 37) ^ (i << 5)), 12'((i * 91) + 12'h5A3), i[1], i[0]);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule